// File: doc/BRIEF.md
# Function Mask Rise Status Register

This block watches the per-function mask levels of a 32-function endpoint and keeps one sticky status bit for each function. A status bit turns on when its function's mask goes from clear to set while a global event enable is on. It does not matter whether local firmware or host software changed the mask. The bit stays on until firmware writes a 1 to its position.

The OR of all status bits drives a level-sensitive local interrupt, which an interrupt mask input can suppress. Firmware reads the status word from a plain output, which has no read side effects. It clears bits through a single-address write port: one strobe plus a 32-bit data word.

No data streams through this block. Every pin is a plain control or status signal and carries no valid/ready handshake, so nothing in the block applies back-pressure.

Top module: `mse_top`

## Requirements
- R1: Status bit k records events of function k. Bits 0 to 3 belong to physical functions 0 to 3, and bits 4 to 31 belong to virtual functions 0 to 27. A rise on mask input k affects status bit k and no other bit.
- R2: A rising mask level sets its status bit. When `fn_mask_lvl[k]` goes from 0 to 1 before a clock edge, status bit k reads 1 after that edge.
- R3: A mask level that stays at 1, or that falls from 1 to 0, sets no status bit.
- R4: While `evt_en` is 0, rising mask levels are not recorded, and these lost events do not appear later when `evt_en` returns to 1.
- R5: A clock edge with `wr_en` high clears every status bit whose `wr_data` bit is 1 and keeps every bit whose `wr_data` bit is 0. With `wr_en` low, `wr_data` has no effect.
- R6: `local_irq` is 1 exactly when at least one status bit is 1 and `irq_mask` is 0. A change of `irq_mask` changes `local_irq` in the same cycle and changes no status bit.
- R7: `local_irq` stays asserted until every set status bit has been cleared. Clearing only some of the set bits keeps it high.
- R8: After reset all status bits are 0. A mask that is already 1 when reset is released does not count as a rise.
- R9: If a rise and a write-1 clear hit the same bit on the same edge, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fn_mask_lvl | input | 32 | Current mask level of each function |
| evt_en | input | 1 | Global enable for recording rises |
| irq_mask | input | 1 | 1 suppresses the local interrupt |
| wr_en | input | 1 | Write strobe for the status register |
| wr_data | input | 32 | Write-one-to-clear data |
| status_q | output | 32 | Readable status word |
| local_irq | output | 1 | Level interrupt to local firmware |

## Verification
A mask rise and a write-1 clear both show up in `status_q` one clock edge after they are presented. `local_irq` follows `status_q` and `irq_mask` with no added register, so it is already valid in the cycle of the change. The bench changes inputs just after a rising edge and waits one edge for register results. It checks `irq_mask` effects after only a short delay in the same cycle. All samples are taken 1 ns after the edge, well clear of it.

// File: rtl/mse_pkg.sv
package mse_pkg;
  localparam int unsigned FN_COUNT  = 32;
  localparam int unsigned PF_COUNT  = 4;
  localparam int unsigned VF_COUNT  = FN_COUNT - PF_COUNT;
  typedef logic [FN_COUNT-1:0] fn_vec_t;
endpackage

// File: rtl/mse_rise_det.sv
module mse_rise_det #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  logic [N-1:0] lvl_prev;

  // Previous level resets to ones so a level already high at reset release
  // is not taken as a rise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_prev <= '1;
    else        lvl_prev <= lvl;
  end

  assign rise = lvl & ~lvl_prev;
endmodule

// File: rtl/mse_stat_bank.sv
module mse_stat_bank #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_req,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] stat
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stat[i] <= 1'b0;
      else if (set_req[i]) stat[i] <= 1'b1;   // set beats clear
      else if (clr_req[i]) stat[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/mse_irq_gen.sv
module mse_irq_gen #(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] stat,
  input  logic         irq_mask,
  output logic         irq
);
  assign irq = (|stat) & ~irq_mask;
endmodule

// File: rtl/mse_top.sv
module mse_top
  import mse_pkg::*;
#(
  parameter int unsigned N = FN_COUNT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] fn_mask_lvl,
  input  logic         evt_en,
  input  logic         irq_mask,
  input  logic         wr_en,
  input  logic [N-1:0] wr_data,
  output logic [N-1:0] status_q,
  output logic         local_irq
);
  logic [N-1:0] rise_vec;
  logic [N-1:0] set_vec;
  logic [N-1:0] clr_vec;

  mse_rise_det #(.N(N)) u_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (fn_mask_lvl),
    .rise (rise_vec)
  );

  assign set_vec = rise_vec & {N{evt_en}};
  assign clr_vec = wr_data & {N{wr_en}};

  mse_stat_bank #(.N(N)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_req(set_vec),
    .clr_req(clr_vec),
    .stat   (status_q)
  );

  mse_irq_gen #(.N(N)) u_irq (
    .stat    (status_q),
    .irq_mask(irq_mask),
    .irq     (local_irq)
  );
endmodule

// File: rtl/mse_chk.sv
module mse_chk #(
  parameter int unsigned N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] fn_mask_lvl,
  input logic         evt_en,
  input logic         irq_mask,
  input logic         wr_en,
  input logic [N-1:0] wr_data,
  input logic [N-1:0] status_q,
  input logic         local_irq
);
  logic [N-1:0] lvl_d;
  logic [N-1:0] rise_c;
  logic [N-1:0] rise_en;
  logic [N-1:0] clr_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= '1;
    else        lvl_d <= fn_mask_lvl;
  end
  assign rise_c  = fn_mask_lvl & ~lvl_d;
  assign rise_en = evt_en ? rise_c : '0;
  assign clr_c   = wr_en ? wr_data : '0;

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_ZERO: assert (status_q == '0); // R8
  end

  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_en |=> ((status_q & $past(rise_c)) == $past(rise_c))); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((wr_data & rise_en) != '0)) |=> ((status_q & $past(wr_data & rise_en)) == $past(wr_data & rise_en))); // R9
  AST_NO_SET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_en |=> ((status_q & ~$past(status_q)) == '0)); // R4
  AST_ONLY_RISES_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(rise_c)) == '0)); // R3
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((status_q & $past(wr_data & ~rise_en)) == '0)); // R5
  AST_W0_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & ~clr_c)) == $past(status_q & ~clr_c))); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !local_irq); // R6
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_mask && status_q != '0) |-> local_irq); // R7
endmodule

bind mse_top mse_chk #(.N(N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fn_mask_lvl(fn_mask_lvl),
  .evt_en     (evt_en),
  .irq_mask   (irq_mask),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .status_q   (status_q),
  .local_irq  (local_irq)
);

// File: tb/tb_mse_top.sv
`timescale 1ns/1ps
module tb_mse_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] fn_mask_lvl = '0;
  logic         evt_en = 1'b0;
  logic         irq_mask = 1'b0;
  logic         wr_en = 1'b0;
  logic [N-1:0] wr_data = '0;
  logic [N-1:0] status_q;
  logic         local_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mse_top dut (
    .clk(clk), .rst_n(rst_n), .fn_mask_lvl(fn_mask_lvl), .evt_en(evt_en),
    .irq_mask(irq_mask), .wr_en(wr_en), .wr_data(wr_data),
    .status_q(status_q), .local_irq(local_irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    wr_en = 1'b1; wr_data = '1;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  // R8: reset with masks already high
  task automatic t_reset();
    fn_mask_lvl = '1; evt_en = 1'b1;
    rst_n = 1'b0;
    tick(); tick();
    chk(status_q == '0, "R8 reset", status_q, '0);
    rst_n = 1'b1;
    tick(); tick();
    chk(status_q == '0, "R8 high at release", status_q, '0);
    chk(local_irq == 1'b0, "R8 irq idle", {31'b0, local_irq}, '0);
    fn_mask_lvl = '0;
    tick();
  endtask

  // R1 R2: single rises land on their own bit
  task automatic t_map();
    int idx [4] = '{0, 3, 4, 31};
    foreach (idx[j]) begin
      fn_mask_lvl = '0; tick();
      fn_mask_lvl[idx[j]] = 1'b1;
      tick();
      chk(status_q == (32'h1 << idx[j]), "R1 R2 bit map", status_q, 32'h1 << idx[j]);
      clear_all();
    end
    fn_mask_lvl = '0; tick();
    fn_mask_lvl = 32'hA5A5_0F0F;
    tick();
    chk(status_q == 32'hA5A5_0F0F, "R2 multi rise", status_q, 32'hA5A5_0F0F);
    clear_all();
  endtask

  // R3: steady high and falling edges set nothing
  task automatic t_no_edge();
    tick(); tick();
    chk(status_q == '0, "R3 steady high", status_q, '0);
    fn_mask_lvl = '0;
    tick(); tick();
    chk(status_q == '0, "R3 fall", status_q, '0);
  endtask

  // R4: enable gating
  task automatic t_enable();
    evt_en = 1'b0;
    fn_mask_lvl = 32'h0000_00F0;
    tick();
    chk(status_q == '0, "R4 disabled rise", status_q, '0);
    evt_en = 1'b1;
    tick(); tick();
    chk(status_q == '0, "R4 no late record", status_q, '0);
    fn_mask_lvl = '0; tick();
  endtask

  // R5: write one clears, zero keeps, no strobe ignored
  task automatic t_w1c();
    fn_mask_lvl = 32'h8000_00FF;
    tick();
    fn_mask_lvl = '0;
    wr_en = 1'b0; wr_data = '1;
    tick();
    chk(status_q == 32'h8000_00FF, "R5 no strobe", status_q, 32'h8000_00FF);
    wr_en = 1'b1; wr_data = 32'h0000_000F;
    tick();
    wr_en = 1'b0; wr_data = '0;
    chk(status_q == 32'h8000_00F0, "R5 partial clear", status_q, 32'h8000_00F0);
    clear_all();
    chk(status_q == '0, "R5 full clear", status_q, '0);
  endtask

  // R6 R7: interrupt mask and hold
  task automatic t_irq();
    fn_mask_lvl = 32'h0000_0011;
    tick();
    fn_mask_lvl = '0;
    chk(local_irq == 1'b1, "R6 irq on", {31'b0, local_irq}, 32'h1);
    irq_mask = 1'b1; #1;
    chk(local_irq == 1'b0, "R6 masked", {31'b0, local_irq}, '0);
    chk(status_q == 32'h11, "R6 status kept", status_q, 32'h11);
    irq_mask = 1'b0; #1;
    chk(local_irq == 1'b1, "R6 unmasked", {31'b0, local_irq}, 32'h1);
    tick();
    wr_en = 1'b1; wr_data = 32'h1;
    tick();
    wr_en = 1'b0; wr_data = '0;
    chk(local_irq == 1'b1, "R7 partial hold", {31'b0, local_irq}, 32'h1);
    wr_en = 1'b1; wr_data = 32'h10;
    tick();
    wr_en = 1'b0; wr_data = '0;
    chk(local_irq == 1'b0, "R7 released", {31'b0, local_irq}, '0);
  endtask

  // R9: same-edge set and clear
  task automatic t_collide();
    fn_mask_lvl = 32'h0000_0100;
    tick();
    fn_mask_lvl = 32'h0000_0300;
    wr_en = 1'b1; wr_data = 32'h0000_0300;
    tick();
    wr_en = 1'b0; wr_data = '0;
    chk(status_q == 32'h0000_0200, "R9 set wins", status_q, 32'h0000_0200);
    fn_mask_lvl = '0;
    clear_all();
  endtask

  initial begin
    t_reset();
    t_map();
    fn_mask_lvl = '1; tick();
    clear_all();
    t_no_edge();
    t_enable();
    t_w1c();
    t_irq();
    t_collide();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule